// File: doc/BRIEF.md
# Ethernet PHY Control Word

This block holds the primary control word of an Ethernet transceiver's management register set. A station management agent reaches it through a plain parallel write port with a continuously driven readback. The serial framing that feeds that port sits outside the block. The word carries four controls:

- auto-negotiation enable;
- low-power mode;
- data-path isolation;
- a self-clearing restart of auto-negotiation.

The block turns those controls into the signals the rest of the transceiver needs:

- gated MAC-side outputs, with an output-enable for the pads;
- blocked MAC-side inputs;
- a tri-state request for the twisted-pair transmit driver;
- a function-enable for the internal logic;
- a one-cycle restart strobe to the auto-negotiation engine;
- a one-cycle clear request for the latching status bits held elsewhere in the register set.

The reset default of the isolate control follows the strapped PHY address. A transceiver strapped to address zero comes up disconnected from the MAC.

Reset is asserted asynchronously and released through a two-stage synchronizer. Internal state therefore leaves reset on the second rising clock edge after `rst_n` goes high.

Top module: `phy_ctl_word`

## Requirements
- R1: While reset is held and after its release, `rd_data` bit 12 (auto-negotiation enable) reads 1 and bit 11 (low power) reads 0. All bits other than 12, 11 and 10 read 0. `lat_clr` and `an_restart` are 0.
- R2: The reset value of `rd_data` bit 10 (isolate) is 1 when `phy_addr` is 0 during reset, and 0 for any other address.
- R3: A cycle with `wr_en`=1 loads bits 12, 11 and 10 of `wr_data`. The new values read back from the next cycle. Bit 9 and all other bits always read 0.
- R4: While the isolate bit is 1, `mac_oe` is 0. All gated MAC-side outputs (`mac_rxd`, `mac_rxdv`, `mac_rxer`, `mac_col`, `mac_crs`, `mac_txclk`, `mac_rxclk`) are 0. `core_txd`, `core_txen` and `core_txer` are 0 whatever `mac_txd`, `mac_txen` and `mac_txer` carry.
- R5: Writes and readback keep working while the isolate bit is 1.
- R6: While the low-power bit is 1, the gated MAC-side outputs and the core-side transmit inputs are 0. `tp_tri_req` is 1 and `func_en` is 0. `mac_oe` stays 1 unless the isolate bit is also 1.
- R7: `lat_clr` is 1 for exactly the one cycle after a write that takes bit 11 from 0 to 1. A write that leaves bit 11 at 1 produces no pulse.
- R8: A write with bit 9 = 1 and bit 12 = 1 while `sw_mode` = 1 drives `an_restart` to 1 during that same cycle.
- R9: When the written bit 12 is 0, or `sw_mode` is 0, a write with bit 9 = 1 leaves `an_restart` at 0.
- R10: With isolate and low power both 0, every MAC-side and core-side output equals its source, `mac_oe` is 1, `func_en` is 1 and `tp_tri_req` is 0.
- R11: `an_enable` equals the stored bit 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_addr | input | 5 | Strapped PHY address, sampled during reset |
| sw_mode | input | 1 | Hardware/software strap, 1 = software control |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current control word |
| an_enable | output | 1 | Auto-negotiation enabled |
| an_restart | output | 1 | One-cycle restart strobe to auto-negotiation |
| lat_clr | output | 1 | One-cycle clear request for latching status bits |
| func_en | output | 1 | Internal functions enabled (0 in low power) |
| tp_tri_req | output | 1 | Twisted-pair transmit tri-state request |
| mac_oe | output | 1 | MAC-side output pad enable |
| core_rxd | input | 4 | Receive nibble from the core |
| core_rxdv | input | 1 | Receive valid from the core |
| core_rxer | input | 1 | Receive error from the core |
| core_col | input | 1 | Collision from the core |
| core_crs | input | 1 | Carrier sense from the core |
| core_txclk | input | 1 | Transmit clock from the core |
| core_rxclk | input | 1 | Receive clock from the core |
| mac_rxd | output | 4 | Gated receive nibble to the MAC |
| mac_rxdv | output | 1 | Gated receive valid |
| mac_rxer | output | 1 | Gated receive error |
| mac_col | output | 1 | Gated collision |
| mac_crs | output | 1 | Gated carrier sense |
| mac_txclk | output | 1 | Gated transmit clock |
| mac_rxclk | output | 1 | Gated receive clock |
| mac_txd | input | 4 | Transmit nibble from the MAC |
| mac_txen | input | 1 | Transmit enable from the MAC |
| mac_txer | input | 1 | Transmit error from the MAC |
| core_txd | output | 4 | Blocked transmit nibble to the core |
| core_txen | output | 1 | Blocked transmit enable |
| core_txer | output | 1 | Blocked transmit error |

## Verification
The stored isolate and low-power bits are the only state behind every gating output. A wrong bit shows in the cycle after the write that set it, both on `rd_data` and on every MAC-side and core-side pin. A stale copy of the previous low-power value would show as a missing or repeated `lat_clr` pulse one cycle after the write. The restart path holds no state, so a wrong qualification shows on `an_restart` within the write cycle itself. A wrong isolate default shows on the first readback after reset.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned SIDE_W = 6;

  localparam int unsigned B_ANEN = 12;
  localparam int unsigned B_LOWP = 11;
  localparam int unsigned B_ISOL = 10;
  localparam int unsigned B_RSTA = 9;

  typedef struct packed {
    logic an_en;
    logic lowp;
    logic isol;
  } ctl_t;
endpackage

// File: rtl/phy_ctl_rst_sync.sv
module phy_ctl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/phy_ctl_regs.sv
module phy_ctl_regs
  import phy_ctl_pkg::*;
#(
  parameter int unsigned W  = WORD_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] phy_addr,
  input  logic          sw_mode,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  rd_data,
  output ctl_t          ctl,
  output logic          an_restart,
  output logic          lat_clr
);
  ctl_t ctl_q, ctl_d;
  logic lowp_prev_q, lowp_prev_d;
  logic iso_dflt;

  assign iso_dflt = (phy_addr == '0);

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) begin
      ctl_d.an_en = wr_data[B_ANEN];
      ctl_d.lowp  = wr_data[B_LOWP];
      ctl_d.isol  = wr_data[B_ISOL];
    end
    lowp_prev_d = ctl_q.lowp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q.an_en <= 1'b1;
      ctl_q.lowp  <= 1'b0;
      ctl_q.isol  <= iso_dflt;
      lowp_prev_q <= 1'b0;
    end else begin
      ctl_q       <= ctl_d;
      lowp_prev_q <= lowp_prev_d;
    end
  end

  always_comb begin
    rd_data          = '0;
    rd_data[B_ANEN]  = ctl_q.an_en;
    rd_data[B_LOWP]  = ctl_q.lowp;
    rd_data[B_ISOL]  = ctl_q.isol;
  end

  assign ctl        = ctl_q;
  assign an_restart = wr_en & wr_data[B_RSTA] & wr_data[B_ANEN] & sw_mode;
  assign lat_clr    = ctl_q.lowp & ~lowp_prev_q;

  p_latclr_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lat_clr |=> !lat_clr);
  p_latclr_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lat_clr |-> ($past(wr_en) && !$past(ctl_q.lowp)));
  p_restart_anen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    an_restart |=> ctl_q.an_en);
endmodule

// File: rtl/phy_ctl_gate.sv
module phy_ctl_gate
  import phy_ctl_pkg::*;
#(
  parameter int unsigned NW = NIB_W,
  parameter int unsigned SW = SIDE_W
) (
  input  ctl_t          ctl,
  input  logic [NW-1:0] rx_nib_in,
  input  logic [SW-1:0] rx_side_in,
  output logic [NW-1:0] rx_nib_out,
  output logic [SW-1:0] rx_side_out,
  input  logic [NW-1:0] tx_nib_in,
  input  logic [1:0]    tx_side_in,
  output logic [NW-1:0] tx_nib_out,
  output logic [1:0]    tx_side_out,
  output logic          oe,
  output logic          func_en,
  output logic          tri_req
);
  logic block;
  assign block = ctl.lowp | ctl.isol;

  for (genvar i = 0; i < NW; i++) begin : g_nib
    assign rx_nib_out[i] = rx_nib_in[i] & ~block;
    assign tx_nib_out[i] = tx_nib_in[i] & ~block;
  end

  for (genvar j = 0; j < SW; j++) begin : g_side
    assign rx_side_out[j] = rx_side_in[j] & ~block;
  end

  for (genvar k = 0; k < 2; k++) begin : g_txside
    assign tx_side_out[k] = tx_side_in[k] & ~block;
  end

  assign oe      = ~ctl.isol;
  assign func_en = ~ctl.lowp;
  assign tri_req = ctl.lowp;
endmodule

// File: rtl/phy_ctl_word.sv
module phy_ctl_word
  import phy_ctl_pkg::*;
#(
  parameter int unsigned W  = WORD_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned NW = NIB_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] phy_addr,
  input  logic          sw_mode,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  rd_data,
  output logic          an_enable,
  output logic          an_restart,
  output logic          lat_clr,
  output logic          func_en,
  output logic          tp_tri_req,
  output logic          mac_oe,
  input  logic [NW-1:0] core_rxd,
  input  logic          core_rxdv,
  input  logic          core_rxer,
  input  logic          core_col,
  input  logic          core_crs,
  input  logic          core_txclk,
  input  logic          core_rxclk,
  output logic [NW-1:0] mac_rxd,
  output logic          mac_rxdv,
  output logic          mac_rxer,
  output logic          mac_col,
  output logic          mac_crs,
  output logic          mac_txclk,
  output logic          mac_rxclk,
  input  logic [NW-1:0] mac_txd,
  input  logic          mac_txen,
  input  logic          mac_txer,
  output logic [NW-1:0] core_txd,
  output logic          core_txen,
  output logic          core_txer
);
  localparam int unsigned SW = SIDE_W;

  logic          rst_n_int;
  ctl_t          ctl;
  logic [SW-1:0] side_in, side_out;
  logic [1:0]    txs_in, txs_out;

  phy_ctl_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  phy_ctl_regs #(.W(W), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n_int), .phy_addr(phy_addr), .sw_mode(sw_mode),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .ctl(ctl),
    .an_restart(an_restart), .lat_clr(lat_clr)
  );

  assign side_in = {core_rxclk, core_txclk, core_crs, core_col, core_rxer, core_rxdv};
  assign {mac_rxclk, mac_txclk, mac_crs, mac_col, mac_rxer, mac_rxdv} = side_out;
  assign txs_in  = {mac_txer, mac_txen};
  assign {core_txer, core_txen} = txs_out;

  phy_ctl_gate #(.NW(NW), .SW(SW)) u_gate (
    .ctl(ctl), .rx_nib_in(core_rxd), .rx_side_in(side_in),
    .rx_nib_out(mac_rxd), .rx_side_out(side_out),
    .tx_nib_in(mac_txd), .tx_side_in(txs_in),
    .tx_nib_out(core_txd), .tx_side_out(txs_out),
    .oe(mac_oe), .func_en(func_en), .tri_req(tp_tri_req)
  );

  assign an_enable = ctl.an_en;

  p_iso_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n_int)
    rd_data[B_ISOL] |-> (!mac_oe && !core_txen && core_txd == '0 && !mac_rxdv));
  p_lowp_tri_r6: assert property (@(posedge clk) disable iff (!rst_n_int)
    rd_data[B_LOWP] |-> (tp_tri_req && !func_en && mac_rxd == '0 && !core_txer));
  p_restart_ro_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
    an_restart |=> !rd_data[B_RSTA]);
endmodule

// File: tb/sim_phy_ctl_word.sv
module sim_phy_ctl_word;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, sw_mode, wr_en;
  logic [4:0]  phy_addr;
  logic [15:0] wr_data, rd_data;
  logic an_enable, an_restart, lat_clr, func_en, tp_tri_req, mac_oe;
  logic [3:0] core_rxd, mac_rxd, mac_txd, core_txd;
  logic core_rxdv, core_rxer, core_col, core_crs, core_txclk, core_rxclk;
  logic mac_rxdv, mac_rxer, mac_col, mac_crs, mac_txclk, mac_rxclk;
  logic mac_txen, mac_txer, core_txen, core_txer;

  phy_ctl_word u0 (.*);

  int nchk = 0, nfail = 0;
  bit m_an, m_lp, m_iso, m_latp;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(bit an, bit lp, bit iso);
    logic [15:0] w = '0;
    w[12] = an; w[11] = lp; w[10] = iso;
    return w;
  endfunction

  function automatic logic [31:0] exp_pins(bit lp, bit iso, logic [3:0] rxd, logic [5:0] side,
                                           logic [3:0] txd, logic [1:0] txs);
    bit blk = lp | iso;
    return {9'd0, ~iso, ~lp, lp, blk ? 4'd0 : rxd, blk ? 6'd0 : side,
            blk ? 4'd0 : txd, blk ? 2'd0 : txs};
  endfunction

  function automatic logic [31:0] act_pins();
    return {9'd0, mac_oe, func_en, tp_tri_req, mac_rxd,
            {mac_rxclk, mac_txclk, mac_crs, mac_col, mac_rxer, mac_rxdv},
            core_txd, {core_txer, core_txen}};
  endfunction

  task automatic check_pins(string req);
    chk(req, act_pins(), exp_pins(m_lp, m_iso, core_rxd,
        {core_rxclk, core_txclk, core_crs, core_col, core_rxer, core_rxdv},
        mac_txd, {mac_txer, mac_txen}));
  endtask

  task automatic do_reset(logic [4:0] addr);
    @(negedge clk);
    rst_n = 1'b0; phy_addr = addr; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 in-reset word", rd_data, exp_word(1, 0, addr == 0));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_an = 1; m_lp = 0; m_iso = (addr == 0); m_latp = 0;
    chk("R1 word", rd_data, exp_word(1, 0, 0) | (rd_data & 16'h0400));
    chk("R2 isolate default", rd_data[10], addr == 0);
    chk("R1 strobes", {lat_clr, an_restart}, 2'b00);
  endtask

  task automatic step(bit we, logic [15:0] d, bit sw);
    wr_en = we; wr_data = d; sw_mode = sw;
    {core_rxd, core_rxdv, core_rxer, core_col, core_crs, core_txclk, core_rxclk} = 10'($urandom);
    {mac_txd, mac_txen, mac_txer} = 6'($urandom);
    #1;
    chk(we && d[12] && sw && d[9] ? "R8 restart" : "R9 restart gated",
        an_restart, we & d[9] & d[12] & sw);
    chk("R7 lat_clr", lat_clr, m_latp);
    chk("R3 R5 readback", rd_data, exp_word(m_an, m_lp, m_iso));
    chk("R11 an_enable", an_enable, m_an);
    check_pins(m_iso ? "R4 isolate" : (m_lp ? "R6 low power" : "R10 pass"));
    m_latp = we && d[11] && !m_lp;
    if (we) begin m_an = d[12]; m_lp = d[11]; m_iso = d[10]; end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1893));
    rst_n = 1'b0; sw_mode = 1'b1; wr_en = 1'b0; wr_data = '0; phy_addr = 5'd3;
    {core_rxd, core_rxdv, core_rxer, core_col, core_crs, core_txclk, core_rxclk} = '0;
    {mac_txd, mac_txen, mac_txer} = '0;

    do_reset(5'd0);
    step(0, 16'h0, 1);                 // R4 isolated after default
    step(1, 16'h1000, 1);              // R5 write while isolated
    step(0, 16'h0, 1);                 // R10 passthrough
    do_reset(5'd9);
    step(1, 16'h1800, 1);              // R7 enter low power
    step(0, 16'h0, 1);                 // R7 pulse visible
    step(1, 16'h1800, 1);              // R7 stay in low power, no pulse
    step(0, 16'h0, 1);
    step(1, 16'h1200, 1);              // R8 restart accepted
    step(0, 16'h0, 1);
    step(1, 16'h0200, 1);              // R9 bit 12 written 0
    step(1, 16'h1200, 0);              // R9 hardware mode
    step(1, 16'h1C00, 1);              // R6 low power and isolate
    step(0, 16'h0, 1);
    for (int i = 0; i < 400; i++) begin
      logic [15:0] d = 16'($urandom);
      step(($urandom % 3) == 0, d, ($urandom % 4) != 0);
    end
    do_reset(5'd0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #2000000;
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule